// File: doc/BRIEF.md
# Sixteen-bit Compact-Encoding Execution Core

A small sequential processor that runs a short program of 16-bit instructions held in a private instruction memory. The memory is filled through a write port while the core is stopped. A start pulse preloads all eight 32-bit working registers from an input bus, clears the flags, the program counter and the cycle count, and starts fetching at byte address 0. The core retires one instruction per active cycle. A taken branch is followed by two stall cycles, so the cycle counter shows the time that a small in-order pipeline would take to run the program.

The supported set is small: load an 8-bit constant, compare with a constant, subtract a constant, add two registers into a third, copy one register to another, branch when equal, branch always, and return through the link register. The return instruction ends the run. After it retires and its two stall cycles have passed, `done` pulses for one cycle and the core freezes with its register file, flags and cycle count visible. Any other encoding stops the core and raises `illegal` instead.

The FSM has six states. IDLE waits after reset. EXEC fetches, decodes and retires one instruction per cycle. STALL1 and STALL2 are the two penalty cycles after a taken branch. HALT is the frozen state after a return. TRAP is the frozen state after an unsupported encoding. The transitions are as follows. A start pulse moves IDLE, HALT or TRAP to EXEC. EXEC stays in EXEC for a straight-line instruction or an untaken branch. EXEC goes to STALL1 for a taken branch or a return, and to TRAP for an unsupported word. STALL1 always goes to STALL2. STALL2 goes back to EXEC after a branch, or to HALT (pulsing `done`) after a return.

Top module: `tcore_top`

## Requirements
- R1: A start pulse accepted in IDLE, HALT or TRAP loads register i from `init_regs[32*i+31:32*i]`, clears NZCV, sets the program counter to 0 and the cycle count to 0. A program consisting only of the return instruction leaves every register equal to its preloaded value.
- R2: The word `00100 ddd kkkkkkkk` writes the zero-extended constant k into register d. N takes bit 31 of the result and Z is set when the result is zero. C and V keep their values.
- R3: The words `00101 nnn kkkkkkkk` (compare) and `00111 nnn kkkkkkkk` (subtract) compute register n minus k. Subtract writes the result back to n and compare writes no register. Both set N and Z from the result, C when no borrow occurs (n >= k unsigned), and V on signed overflow.
- R4: The word `0001100 mmm nnn ddd` writes register n plus register m into register d. N and Z come from the result, C is the carry out of bit 31, and V is signed overflow.
- R5: The word `0000000000 sss ddd` copies register s into register d. N and Z are updated and C and V are kept.
- R6: The word `1101 0000 oooooooo` branches when Z is 1, to the instruction's address + 4 + 2 × the sign-extended 8-bit o. Otherwise it falls through to address + 2.
- R7: The word `11100 ooooooooooo` always branches, to the instruction's address + 4 + 2 × the sign-extended 11-bit o. Instructions it skips have no effect.
- R8: Each retired instruction adds 1 to the cycle count, and a taken branch or the return adds 2 more. The repeated-addition multiply loop therefore takes 9 + 7 × b cycles for a multiplier b.
- R9: The return word 0x4770 ends the run. `done` is high for exactly one cycle, in the first cycle of HALT. After that the cycle count and the registers stay fixed until the next start.
- R10: Any other word, including branch-if-equal with a non-zero condition and other 0x47xx words, writes no register, holds `illegal` high, and never raises `done`.
- R11: When `imem_we` is high, a clock edge stores `imem_wdata` at halfword index `imem_waddr`. The core fetches the instruction at byte address p from index p/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | IAW (5) | Halfword index to write |
| imem_wdata | input | 16 | Instruction word to write |
| start | input | 1 | Begin a run (preload registers, PC = 0) |
| init_regs | input | 256 | Preload values, register i in bits 32i+31:32i |
| regs | output | 256 | Live register file, same packing |
| nzcv | output | 4 | Flags: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| busy | output | 1 | High in EXEC, STALL1 and STALL2 |
| done | output | 1 | One-cycle pulse on entry to HALT |
| illegal | output | 1 | High while stopped on an unsupported word |
| cycles | output | CNT_W (32) | Modelled cycle count, frozen after the run |

## Verification
The bench uses the default parameters: 32-bit registers, a 32-entry instruction memory and a 32-bit counter. With these, the multiply program fits in memory, and its forward conditional branch and backward unconditional branch both land inside the 64-byte address space. The 32-bit datapath lets random operands reach carry out of bit 31, borrow and signed overflow, so every NZCV rule is exercised. The multiplier is kept at 40 or below, so every run's cycle total stays small, while the multiplicand uses the full 32-bit range to check wrap-around products.

// File: rtl/tcore_pkg.sv
package tcore_pkg;

    typedef enum logic [3:0] {
        OP_MOVI,
        OP_CMPI,
        OP_SUBI,
        OP_ADDR,
        OP_MOVR,
        OP_BEQ,
        OP_B,
        OP_RET,
        OP_BAD
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [2:0]  rd;
        logic [2:0]  rn;
        logic [2:0]  rm;
        logic [7:0]  imm;
        logic [11:0] hoff;   // signed halfword offset
    } dec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EXEC,
        S_STALL1,
        S_STALL2,
        S_HALT,
        S_TRAP
    } state_e;

endpackage

// File: rtl/tcore_imem.sv
module tcore_imem #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tcore_decode.sv
module tcore_decode
    import tcore_pkg::*;
(
    input  logic [15:0] ins,
    output dec_t        dec
);

    always_comb begin
        dec      = '0;
        dec.op   = OP_BAD;
        dec.rd   = ins[2:0];
        dec.rn   = ins[5:3];
        dec.rm   = ins[8:6];
        dec.imm  = ins[7:0];
        dec.hoff = {{4{ins[7]}}, ins[7:0]};
        if (ins[15:11] == 5'b00100) begin
            dec.op = OP_MOVI;
            dec.rd = ins[10:8];
        end else if (ins[15:11] == 5'b00101) begin
            dec.op = OP_CMPI;
            dec.rn = ins[10:8];
        end else if (ins[15:11] == 5'b00111) begin
            dec.op = OP_SUBI;
            dec.rn = ins[10:8];
            dec.rd = ins[10:8];
        end else if (ins[15:9] == 7'b0001100) begin
            dec.op = OP_ADDR;
        end else if (ins[15:6] == 10'b0) begin
            dec.op = OP_MOVR;
            dec.rm = ins[5:3];
        end else if (ins[15:8] == 8'hD0) begin
            dec.op = OP_BEQ;
        end else if (ins[15:11] == 5'b11100) begin
            dec.op   = OP_B;
            dec.hoff = {ins[10], ins[10:0]};
        end else if (ins == 16'h4770) begin
            dec.op = OP_RET;
        end
    end

endmodule

// File: rtl/tcore_alu.sv
module tcore_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c,
    output logic         v
);

    logic [W:0]   sum;
    logic [W-1:0] bx;

    always_comb begin
        bx  = sub ? ~b : b;
        sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
        res = sum[W-1:0];
        c   = sum[W];
        v   = (a[W-1] == bx[W-1]) && (res[W-1] != a[W-1]);
    end

    always_comb begin
        if (sub) begin
            AST_SUB_NO_BORROW: assert (c == (a >= b)); // R3
        end else begin
            AST_ADD_CARRY: assert ({c, res} == ({1'b0, a} + {1'b0, b})); // R4
        end
    end

endmodule

// File: rtl/tcore_regfile.sv
module tcore_regfile #(
    parameter int W    = 32,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [NREG*W-1:0] load_bus,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [W-1:0]    wdata,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [W-1:0]    rd1,
    output logic [W-1:0]    rd2,
    output logic [NREG*W-1:0] flat
);

    logic [W-1:0] rf [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load_en) begin
                q <= load_bus[gi*W +: W];
            end else if (we && (waddr == RAW'(gi))) begin
                q <= wdata;
            end
        end
        assign rf[gi]         = q;
        assign flat[gi*W +: W] = q;
    end

    assign rd1 = rf[ra1];
    assign rd2 = rf[ra2];

endmodule

// File: rtl/tcore_top.sv
module tcore_top
    import tcore_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int IMEM_DEPTH = 32,
    parameter int CNT_W      = 32,
    localparam int NREG      = 8,
    localparam int IAW       = $clog2(IMEM_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   imem_we,
    input  logic [IAW-1:0]         imem_waddr,
    input  logic [15:0]            imem_wdata,
    input  logic                   start,
    input  logic [NREG*DATA_W-1:0] init_regs,
    output logic [NREG*DATA_W-1:0] regs,
    output logic [3:0]             nzcv,
    output logic                   busy,
    output logic                   done,
    output logic                   illegal,
    output logic [CNT_W-1:0]       cycles
);

    localparam int PC_W = IAW + 1;

    state_e              st_q, st_d;
    logic [PC_W-1:0]     pc_q;
    logic [3:0]          flags_q;
    logic [CNT_W-1:0]    cyc_q;
    logic                done_q;
    logic                ret_q;

    logic [15:0]         ins;
    dec_t                dec;
    logic [DATA_W-1:0]   rd1, rd2;
    logic [DATA_W-1:0]   alu_b, alu_res;
    logic                alu_c, alu_v, alu_sub;
    logic [DATA_W-1:0]   wdata;
    logic                wen;
    logic                taken;
    logic                start_ok;
    logic                retire;
    logic [PC_W-1:0]     boff;
    logic [PC_W-1:0]     target;
    logic [3:0]          flags_d;

    tcore_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc_q[PC_W-1:1]),
        .rdata (ins)
    );

    tcore_decode u_dec (
        .ins (ins),
        .dec (dec)
    );

    tcore_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (start_ok),
        .load_bus (init_regs),
        .we       (wen),
        .waddr    (dec.rd),
        .wdata    (wdata),
        .ra1      (dec.rn),
        .ra2      (dec.rm),
        .rd1      (rd1),
        .rd2      (rd2),
        .flat     (regs)
    );

    tcore_alu #(.W(DATA_W)) u_alu (
        .a   (rd1),
        .b   (alu_b),
        .sub (alu_sub),
        .res (alu_res),
        .c   (alu_c),
        .v   (alu_v)
    );

    // ---------------- datapath control ----------------
    always_comb begin
        start_ok = start && (st_q == S_IDLE || st_q == S_HALT || st_q == S_TRAP);
        retire   = (st_q == S_EXEC) && (dec.op != OP_BAD);
        alu_sub  = (dec.op != OP_ADDR);
        alu_b    = (dec.op == OP_ADDR) ? rd2 : {{(DATA_W-8){1'b0}}, dec.imm};

        unique case (dec.op)
            OP_MOVI: wdata = {{(DATA_W-8){1'b0}}, dec.imm};
            OP_MOVR: wdata = rd2;
            default: wdata = alu_res;
        endcase

        wen = retire && (dec.op == OP_MOVI || dec.op == OP_MOVR ||
                         dec.op == OP_SUBI || dec.op == OP_ADDR);

        flags_d = flags_q;
        unique case (dec.op)
            OP_MOVI, OP_MOVR: flags_d = {wdata[DATA_W-1], wdata == '0, flags_q[1:0]};
            OP_CMPI, OP_SUBI, OP_ADDR:
                flags_d = {alu_res[DATA_W-1], alu_res == '0, alu_c, alu_v};
            default: flags_d = flags_q;
        endcase

        taken  = (dec.op == OP_BEQ && flags_q[2]) || dec.op == OP_B || dec.op == OP_RET;
        boff   = PC_W'({{PC_W{dec.hoff[11]}}, dec.hoff, 1'b0});
        target = pc_q + PC_W'(4) + boff;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE, S_HALT, S_TRAP: if (start) st_d = S_EXEC;
            S_EXEC: begin
                if (dec.op == OP_BAD) st_d = S_TRAP;
                else if (taken)       st_d = S_STALL1;
                else                  st_d = S_EXEC;
            end
            S_STALL1: st_d = S_STALL2;
            S_STALL2: st_d = ret_q ? S_HALT : S_EXEC;
            default:  st_d = S_IDLE;
        endcase
    end

    // ---------------- registered outputs and machine state ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
            cyc_q   <= '0;
            done_q  <= 1'b0;
            ret_q   <= 1'b0;
        end else begin
            done_q <= (st_q == S_STALL2) && ret_q;
            if (start_ok) begin
                pc_q    <= '0;
                flags_q <= '0;
                cyc_q   <= '0;
                ret_q   <= 1'b0;
            end else if (retire) begin
                cyc_q   <= cyc_q + CNT_W'(1);
                flags_q <= flags_d;
                pc_q    <= taken ? target : pc_q + PC_W'(2);
                ret_q   <= (dec.op == OP_RET);
            end else if (st_q == S_STALL1 || st_q == S_STALL2) begin
                cyc_q <= cyc_q + CNT_W'(1);
            end
        end
    end

    assign nzcv    = flags_q;
    assign cycles  = cyc_q;
    assign done    = done_q;
    assign busy    = (st_q == S_EXEC) || (st_q == S_STALL1) || (st_q == S_STALL2);
    assign illegal = (st_q == S_TRAP);

    // ---------------- assertions ----------------
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (cyc_q == '0) && (pc_q == '0) && (flags_q == 4'b0)); // R1
    AST_STALL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_STALL1) |=> (st_q == S_STALL2)); // R8
    AST_RETIRE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (cyc_q == $past(cyc_q) + CNT_W'(1))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HALT && !start) |=> ($stable(cyc_q) && $stable(regs))); // R9
    AST_TRAP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal)); // R10
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && dec.op == OP_BAD) |=> $stable(regs)); // R10

endmodule

// File: tb/sim_tcore_top.sv
module sim_tcore_top;

    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             imem_we = 1'b0;
    logic [4:0]       imem_waddr = '0;
    logic [15:0]      imem_wdata = '0;
    logic             start = 1'b0;
    logic [8*W-1:0]   init_regs = '0;
    logic [8*W-1:0]   regs;
    logic [3:0]       nzcv;
    logic             busy, done, illegal;
    logic [31:0]      cycles;

    int nchk = 0;
    int nfail = 0;
    logic saw_done, saw_illegal;

    always #2 clk = ~clk;   // 250 MHz

    tcore_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .start      (start),
        .init_regs  (init_regs),
        .regs       (regs),
        .nzcv       (nzcv),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .cycles     (cycles)
    );

    // ---------- encoders ----------
    function automatic logic [15:0] e_movi(input int d, input logic [7:0] k);
        return {5'b00100, 3'(d), k};
    endfunction
    function automatic logic [15:0] e_cmpi(input int n, input logic [7:0] k);
        return {5'b00101, 3'(n), k};
    endfunction
    function automatic logic [15:0] e_subi(input int n, input logic [7:0] k);
        return {5'b00111, 3'(n), k};
    endfunction
    function automatic logic [15:0] e_add(input int d, input int n, input int m);
        return {7'b0001100, 3'(m), 3'(n), 3'(d)};
    endfunction
    function automatic logic [15:0] e_movr(input int d, input int s);
        return {10'b0, 3'(s), 3'(d)};
    endfunction
    function automatic logic [15:0] e_beq(input logic [7:0] o);
        return {8'hD0, o};
    endfunction
    function automatic logic [15:0] e_b(input logic [10:0] o);
        return {5'b11100, o};
    endfunction
    localparam logic [15:0] RET = 16'h4770;

    // ---------- reference arithmetic: returns {N,Z,C,V} ----------
    function automatic logic [3:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                             input bit is_sub, output logic [31:0] r);
        logic c, v;
        if (is_sub) begin
            r = a - b;
            c = (a >= b);
            v = (a[31] != b[31]) && (r[31] != a[31]);
        end else begin
            r = a + b;
            c = ({32'b0, a} + {32'b0, b}) > 64'hFFFF_FFFF;
            v = (a[31] == b[31]) && (r[31] != a[31]);
        end
        return {r[31], r == 32'b0, c, v};
    endfunction

    // ---------- helpers ----------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rg(input int i);
        return regs[i*W +: W];
    endfunction

    task automatic write_word(input int idx, input logic [15:0] w);
        @(negedge clk);
        imem_we    = 1'b1;
        imem_waddr = 5'(idx);
        imem_wdata = w;
        @(negedge clk);
        imem_we    = 1'b0;
    endtask

    task automatic set_reg(input int i, input logic [31:0] v);
        init_regs[i*W +: W] = v;
    endtask

    task automatic run();
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        saw_done = 1'b0;
        saw_illegal = 1'b0;
        while (!done && !illegal && n < 2000) begin
            @(negedge clk);
            n++;
        end
        saw_done = done;
        saw_illegal = illegal;
        if (n >= 2000) check("watchdog run", 32'd0, 32'd1);
    endtask

    task automatic load_mul();
        write_word(0, e_movi(2, 8'd0));
        write_word(1, e_cmpi(1, 8'd0));
        write_word(2, e_beq(8'd2));
        write_word(3, e_subi(1, 8'd1));
        write_word(4, e_add(2, 2, 0));
        write_word(5, e_b(11'h7FA));
        write_word(6, e_movr(0, 2));
        write_word(7, RET);
    endtask

    task automatic do_mul(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] p;
        p = a * b;
        set_reg(0, a);
        set_reg(1, b);
        run();
        check("R9 done after multiply", {31'b0, saw_done}, 32'd1);
        check("R4 product r0", rg(0), p);
        check("R3 counter r1", rg(1), 32'd0);
        check("R8 multiply cycles", cycles, 32'd9 + 32'd7 * b);
        check("R5 flags after copy", {28'b0, nzcv}, {28'b0, p[31], p == 0, 1'b1, 1'b0});
    endtask

    // ---------- global watchdog ----------
    initial begin
        #(200000 * 4);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // ---------- main ----------
    initial begin
        logic [31:0] x, y, r, cyc_hold;
        logic [3:0]  f;
        void'($urandom(32'd20240517));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1)
        check("R1 reset done", {31'b0, done}, 32'd0);
        check("R1 reset illegal", {31'b0, illegal}, 32'd0);
        check("R1 reset busy", {31'b0, busy}, 32'd0);
        check("R1 reset cycles", cycles, 32'd0);

        // R1: preload with return-only program
        write_word(0, RET);
        for (int i = 0; i < 8; i++) set_reg(i, $urandom());
        run();
        for (int i = 0; i < 8; i++) check("R1 preload kept", rg(i), init_regs[i*W +: W]);
        check("R1 flags cleared", {28'b0, nzcv}, 32'd0);
        check("R8 return cycles", cycles, 32'd3);
        // R9 one-cycle pulse and frozen count
        cyc_hold = cycles;
        @(negedge clk);
        check("R9 done pulse width", {31'b0, done}, 32'd0);
        check("R9 cycles frozen", cycles, cyc_hold);

        // R11 + multiply loop (R6 forward beq, R7 backward b)
        load_mul();
        do_mul(32'd123, 32'd5);
        do_mul(32'd123, 32'd6);
        do_mul(32'hDEAD_BEEF, 32'd0);
        do_mul(32'hFFFF_FFFF, 32'd1);
        for (int t = 0; t < 6; t++) do_mul($urandom(), $urandom_range(40, 0));

        // R2: constant load keeps C,V
        write_word(0, e_cmpi(0, 8'd0));
        write_word(1, e_movi(3, 8'hA5));
        write_word(2, RET);
        set_reg(0, 32'd0);
        run();
        check("R2 constant value", rg(3), 32'h0000_00A5);
        check("R2 flags", {28'b0, nzcv}, {28'b0, 4'b0010});
        check("R8 straight-line cycles", cycles, 32'd5);

        // R3/R4 random ALU operations
        for (int t = 0; t < 24; t++) begin
            int kind;
            logic [7:0] k;
            kind = $urandom_range(2, 0);
            k    = 8'($urandom());
            x    = $urandom();
            y    = $urandom();
            if (t == 0) begin x = 32'h7FFF_FFFF; y = 32'd1; kind = 0; end
            if (t == 1) begin x = 32'hFFFF_FFFF; y = 32'd1; kind = 0; end
            if (t == 2) begin x = 32'h8000_0000; k = 8'd1; kind = 1; end
            if (t == 3) begin x = 32'd5; k = 8'd5; kind = 2; end
            if (t == 4) begin x = 32'd3; k = 8'd200; kind = 1; end
            set_reg(3, x);
            set_reg(4, y);
            set_reg(5, 32'h1111_1111);
            set_reg(6, x);
            set_reg(7, x);
            case (kind)
                0: write_word(0, e_add(5, 3, 4));
                1: write_word(0, e_subi(6, k));
                default: write_word(0, e_cmpi(7, k));
            endcase
            write_word(1, RET);
            run();
            case (kind)
                0: begin
                    f = ref_flags(x, y, 1'b0, r);
                    check("R4 add result", rg(5), r);
                    check("R4 add flags", {28'b0, nzcv}, {28'b0, f});
                end
                1: begin
                    f = ref_flags(x, {24'b0, k}, 1'b1, r);
                    check("R3 sub result", rg(6), r);
                    check("R3 sub flags", {28'b0, nzcv}, {28'b0, f});
                end
                default: begin
                    f = ref_flags(x, {24'b0, k}, 1'b1, r);
                    check("R3 cmp no write", rg(7), x);
                    check("R3 cmp flags", {28'b0, nzcv}, {28'b0, f});
                end
            endcase
            check("R8 two-instruction cycles", cycles, 32'd4);
        end

        // R7: forward branch skipping a word
        write_word(0, e_b(11'd0));
        write_word(1, e_movi(0, 8'h55));
        write_word(2, RET);
        set_reg(0, 32'hCAFE_0001);
        run();
        check("R7 skipped word no effect", rg(0), 32'hCAFE_0001);
        check("R8 branch plus return cycles", cycles, 32'd6);

        // R6: untaken then backward taken beq
        write_word(0, e_b(11'd1));        // to 6
        write_word(1, e_movi(1, 8'd9));   // 2
        write_word(2, RET);               // 4
        write_word(3, e_cmpi(2, 8'd1));   // 6
        write_word(4, e_beq(8'hFA));      // 8 -> 8+4-12 = 0 ... loops
        write_word(5, RET);               // a
        set_reg(1, 32'd0);
        set_reg(2, 32'd0);
        run();
        check("R6 untaken falls through", rg(1), 32'd0);
        check("R8 untaken beq cycles", cycles, 32'd3 + 1 + 1 + 3);
        write_word(3, e_cmpi(2, 8'd0));
        write_word(4, e_beq(8'hFC));      // 8+4-8 = 4 -> RET
        run();
        check("R6 backward taken to return", rg(1), 32'd0);
        check("R8 taken beq cycles", cycles, 32'd3 + 1 + 3 + 3);

        // R10: unsupported words
        for (int t = 0; t < 3; t++) begin
            write_word(0, e_movi(1, 8'd7));
            case (t)
                0: write_word(1, 16'hBF00);
                1: write_word(1, 16'hD100);
                default: write_word(1, 16'h4778);
            endcase
            write_word(2, e_movi(2, 8'd9));
            write_word(3, RET);
            set_reg(2, 32'h0BAD_0BAD);
            run();
            check("R10 illegal raised", {31'b0, saw_illegal}, 32'd1);
            check("R10 no done", {31'b0, saw_done}, 32'd0);
            check("R10 earlier write kept", rg(1), 32'd7);
            repeat (4) @(negedge clk);
            check("R10 later word not run", rg(2), 32'h0BAD_0BAD);
            check("R10 illegal held", {31'b0, illegal}, 32'd1);
        end

        // R11: rewrite one word and rerun
        write_word(0, e_movi(4, 8'd42));
        write_word(1, RET);
        run();
        check("R11 rewritten program", rg(4), 32'd42);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule